// File: doc/BRIEF.md
# Processor Fault Entry Controller

This block sits beside a processor's sequencer and turns a fault request into the recorded fault state and the move into the fault cycle. A request carries a fault number, a sub-code and the kind of cycle the processor was in when the fault came up. On acceptance the block records the number, the sub-code, a fault-in-fetch flag, a fault address field and a connect channel field. It also steps a small fault counter held in the low bits of a cycle-bits register, counts the instruction when the fault interrupts an execute cycle, and pulses a strobe that sends the sequencer into the fault cycle.

A fault that arrives while the processor is running the fault-execute cycle (fetching the fault pair) is recorded as a Trouble fault, and the block sets a trouble flag. If a second such fault follows while the flag is still set and no interrupt is pending, the block raises a sticky cascade-stop signal so that the processor can halt instead of looping.

Requests use a ready/valid handshake. After an accepted request the block is busy for one cycle, and `req_ready` is low for that cycle.

Top module: `fault_entry_ctrl`

## Requirements
- R1: A request whose number has any bit above bit 4 set is recorded as fault 31 (Trouble).
- R2: Each accepted request increments the low 3 bits of `cyc_bits` modulo 8. The upper 9 bits keep their reset value (the reset value of `cyc_bits` is the parameter `CYC_RESET`, default 12'hA55).
- R3: `fif` is 1 after an accepted request only if `cycle_kind` was fetch (2'b00). Otherwise it is 0. The other encodings are execute 2'b01, fault-execute 2'b10 and other 2'b11.
- R4: `fault_addr` always equals the recorded 5-bit fault number.
- R5: A request accepted during fault-execute is recorded as number 31 with a sub-code of zero. In every other cycle the sanitized number and the request's sub-code are recorded.
- R6: A fault-execute request that finds `trouble` already set leaves `trouble` set, and it sets the sticky `cascade_stop` if `irq_pending` is 0. A fault-execute request that finds `trouble` clear sets `trouble`.
- R7: A request accepted in any cycle other than fault-execute clears `trouble`. `cascade_stop` stays set until reset.
- R8: When the sanitized number is 8 (connect), `chan` takes the low 3 bits of the sub-code. Otherwise `chan` is 0.
- R9: `instr_cnt` increments by one for each request accepted in an execute cycle. `fault_enter` is high for exactly the cycle after each acceptance.
- R10: `req_ready` is low in the cycle after an acceptance. A request held valid during that cycle is not taken and changes no state.
- R11: After reset, all recorded fields, `trouble`, `cascade_stop`, `fault_enter` and `instr_cnt` are zero, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fault request present |
| req_num | input | NUM_IN_W (8) | Raw fault number |
| req_sub | input | SUB_W (16) | Fault sub-code |
| cycle_kind | input | 2 | Current cycle: 00 fetch, 01 execute, 10 fault-execute, 11 other |
| irq_pending | input | 1 | Some interrupt is pending |
| req_ready | output | 1 | Request can be accepted this cycle |
| fault_num | output | 5 | Recorded fault number |
| fault_sub | output | SUB_W | Recorded sub-code |
| fault_addr | output | 5 | Fault address field |
| fif | output | 1 | Fault occurred in a fetch cycle |
| chan | output | 3 | Connect channel field |
| cyc_bits | output | CYC_W (12) | Cycle-bits register with fault counter in the low bits |
| trouble | output | 1 | Trouble-cycle flag |
| cascade_stop | output | 1 | Sticky cascaded-fault stop |
| instr_cnt | output | ICNT_W (16) | Instruction counter |
| fault_enter | output | 1 | Strobe: sequencer enters the fault cycle |

## Verification
The assertions assume that `cycle_kind`, `req_num`, `req_sub` and `irq_pending` hold steady around each rising edge at which `req_valid` is high. They also assume that reset is asserted from time zero. The bench changes every input on the falling edge only and keeps reset low through the first edges. Out-of-range numbers and all four cycle encodings are driven on purpose, so the properties see every branch.

// File: rtl/fe_pkg.sv
package fe_pkg;
    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_EXEC  = 2'b01,
        CYC_FEXEC = 2'b10,
        CYC_OTHER = 2'b11
    } cyc_kind_e;

    localparam int FN_W = 5;
    localparam logic [FN_W-1:0] FN_TROUBLE = 5'd31;
    localparam logic [FN_W-1:0] FN_CONNECT = 5'd8;
endpackage

// File: rtl/fe_sanitize.sv
module fe_sanitize #(
    parameter int IN_W = 8
) (
    input  logic [IN_W-1:0]         raw,
    output logic [fe_pkg::FN_W-1:0] num
);
    import fe_pkg::*;
    generate
        if (IN_W > FN_W) begin : g_wide
            always_comb begin
                if (|raw[IN_W-1:FN_W]) num = FN_TROUBLE;
                else                   num = raw[FN_W-1:0];
            end
        end else begin : g_narrow
            always_comb num = FN_W'(raw);
        end
    endgenerate
endmodule

// File: rtl/fe_trouble.sv
module fe_trouble (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic in_fexec,
    input  logic irq_pending,
    input  logic trouble_q,
    input  logic cascade_q,
    output logic trouble_d,
    output logic cascade_d
);
    always_comb begin
        trouble_d = trouble_q;
        cascade_d = cascade_q;
        if (take) begin
            if (in_fexec) begin
                if (trouble_q && !irq_pending) cascade_d = 1'b1;
                trouble_d = 1'b1;
            end else begin
                trouble_d = 1'b0;
            end
        end
    end

    // R6: repeated fault-execute fault with no interrupt leads to a stop
    p_cascade_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_fexec && trouble_q && !irq_pending) |=> cascade_q)
        else $error("cascade not raised");

    // R7: fault outside fault-execute drops the trouble flag
    p_trouble_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_fexec) |=> !trouble_q)
        else $error("trouble not cleared");
endmodule

// File: rtl/fault_entry_ctrl.sv
module fault_entry_ctrl #(
    parameter int              NUM_IN_W  = 8,
    parameter int              SUB_W     = 16,
    parameter int              CYC_W     = 12,
    parameter int              FCT_W     = 3,
    parameter int              ICNT_W    = 16,
    parameter int              CHAN_W    = 3,
    parameter logic [CYC_W-1:0] CYC_RESET = 12'hA55
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [NUM_IN_W-1:0]      req_num,
    input  logic [SUB_W-1:0]         req_sub,
    input  logic [1:0]               cycle_kind,
    input  logic                     irq_pending,
    output logic                     req_ready,
    output logic [fe_pkg::FN_W-1:0]  fault_num,
    output logic [SUB_W-1:0]         fault_sub,
    output logic [fe_pkg::FN_W-1:0]  fault_addr,
    output logic                     fif,
    output logic [CHAN_W-1:0]        chan,
    output logic [CYC_W-1:0]         cyc_bits,
    output logic                     trouble,
    output logic                     cascade_stop,
    output logic [ICNT_W-1:0]        instr_cnt,
    output logic                     fault_enter
);
    import fe_pkg::*;

    localparam int UPPER_W = CYC_W - FCT_W;
    localparam logic [UPPER_W-1:0] CYC_UPPER = CYC_RESET[CYC_W-1:FCT_W];
    localparam logic [FCT_W-1:0]   FCT_INIT  = CYC_RESET[FCT_W-1:0];

    typedef struct packed {
        logic [FN_W-1:0]   num;
        logic [SUB_W-1:0]  sub;
        logic [FN_W-1:0]   addr;
        logic              fif;
        logic [CHAN_W-1:0] chan;
        logic [FCT_W-1:0]  fct;
        logic              trouble;
        logic              cascade;
        logic [ICNT_W-1:0] icnt;
        logic              busy;
    } fe_state_t;

    fe_state_t       st_d, st_q;
    cyc_kind_e       kind;
    logic [FN_W-1:0] clean_num;
    logic            take, in_fexec;
    logic            trouble_nx, cascade_nx;

    assign kind      = cyc_kind_e'(cycle_kind);
    assign req_ready = !st_q.busy;
    assign take      = req_valid && req_ready;
    assign in_fexec  = (kind == CYC_FEXEC);

    fe_sanitize #(.IN_W(NUM_IN_W)) u_san (
        .raw (req_num),
        .num (clean_num)
    );

    fe_trouble u_trb (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .in_fexec    (in_fexec),
        .irq_pending (irq_pending),
        .trouble_q   (st_q.trouble),
        .cascade_q   (st_q.cascade),
        .trouble_d   (trouble_nx),
        .cascade_d   (cascade_nx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.busy    = take;
        st_d.trouble = trouble_nx;
        st_d.cascade = cascade_nx;
        if (take) begin
            st_d.num  = in_fexec ? FN_TROUBLE : clean_num;
            st_d.sub  = in_fexec ? '0 : req_sub;
            st_d.addr = in_fexec ? FN_TROUBLE : clean_num;
            st_d.fif  = (kind == CYC_FETCH);
            st_d.chan = (clean_num == FN_CONNECT) ? req_sub[CHAN_W-1:0] : '0;
            st_d.fct  = st_q.fct + 1'b1;
            if (kind == CYC_EXEC) st_d.icnt = st_q.icnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.fct <= FCT_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_num    = st_q.num;
    assign fault_sub    = st_q.sub;
    assign fault_addr   = st_q.addr;
    assign fif          = st_q.fif;
    assign chan         = st_q.chan;
    assign cyc_bits     = {CYC_UPPER, st_q.fct};
    assign trouble      = st_q.trouble;
    assign cascade_stop = st_q.cascade;
    assign instr_cnt    = st_q.icnt;
    assign fault_enter  = st_q.busy;

    // R1: out-of-range numbers become Trouble
    p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (|req_num[NUM_IN_W-1:FN_W])) |=> (fault_num == FN_TROUBLE))
        else $error("range");

    // R2: counter steps by one per accepted fault
    p_fct_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cyc_bits[FCT_W-1:0] == $past(cyc_bits[FCT_W-1:0]) + 1'b1))
        else $error("fct");

    // R5: fault-execute fault recorded as Trouble with empty sub-code
    p_fexec_trb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_fexec) |=> (fault_num == FN_TROUBLE && fault_sub == '0))
        else $error("fexec");

    // R9: instruction counter follows execute-cycle faults
    p_icnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == CYC_EXEC) |=> (instr_cnt == $past(instr_cnt) + 1'b1))
        else $error("icnt");

    // R10: no state change without acceptance
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(fault_num) && $stable(cyc_bits) && $stable(instr_cnt)))
        else $error("hold");
endmodule

// File: tb/fault_entry_ctrl_tb.sv
module fault_entry_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_num = '0;
    logic [15:0] req_sub = '0;
    logic [1:0]  cycle_kind = 2'b11;
    logic        irq_pending = 1'b0;
    logic        req_ready, fif, trouble, cascade_stop, fault_enter;
    logic [4:0]  fault_num, fault_addr;
    logic [15:0] fault_sub, instr_cnt;
    logic [2:0]  chan;
    logic [11:0] cyc_bits;

    int total = 0;
    int bad = 0;
    int e_fct, e_icnt, e_trb, e_casc;

    always #10 clk = ~clk;

    fault_entry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_num(req_num),
        .req_sub(req_sub), .cycle_kind(cycle_kind), .irq_pending(irq_pending),
        .req_ready(req_ready), .fault_num(fault_num), .fault_sub(fault_sub),
        .fault_addr(fault_addr), .fif(fif), .chan(chan), .cyc_bits(cyc_bits),
        .trouble(trouble), .cascade_stop(cascade_stop), .instr_cnt(instr_cnt),
        .fault_enter(fault_enter)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one request, model update and full check; leaves block idle again
    task automatic send(input int num, input int sub, input int cyc, input bit irq);
        int sn, rec;
        @(negedge clk);
        chk("R10 ready before request", req_ready, 1);
        req_valid = 1'b1; req_num = num[7:0]; req_sub = sub[15:0];
        cycle_kind = cyc[1:0]; irq_pending = irq;
        sn  = (num > 31) ? 31 : num;
        rec = (cyc == 2) ? 31 : sn;
        e_fct = (e_fct + 1) % 8;
        if (cyc == 1) e_icnt++;
        if (cyc == 2) begin
            if (e_trb == 1 && !irq) e_casc = 1;
            e_trb = 1;
        end else e_trb = 0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1/R5 number", fault_num, rec);
        chk("R5 sub-code", fault_sub, (cyc == 2) ? 0 : (sub & 16'hFFFF));
        chk("R4 address", fault_addr, rec);
        chk("R3 fetch flag", fif, (cyc == 0) ? 1 : 0);
        chk("R8 channel", chan, (sn == 8) ? (sub & 7) : 0);
        chk("R2 cycle bits", cyc_bits, 12'hA50 | e_fct);
        chk("R6/R7 trouble", trouble, e_trb);
        chk("R6 cascade", cascade_stop, e_casc);
        chk("R9 instr count", instr_cnt, e_icnt);
        chk("R9 enter strobe", fault_enter, 1);
        chk("R10 busy", req_ready, 0);
        @(negedge clk);
        chk("R9 strobe one cycle", fault_enter, 0);
    endtask

    task automatic t_reset;
        chk("R11 num", fault_num, 0);
        chk("R11 cyc", cyc_bits, 12'hA55);
        chk("R11 trouble", trouble + cascade_stop + fault_enter, 0);
        chk("R11 icnt", instr_cnt, 0);
        chk("R11 ready", req_ready, 1);
    endtask

    task automatic t_basic;
        send(7, 16'h1234, 0, 0);
        send(13, 16'h00F0, 1, 0);
        send(20, 16'hBEEF, 3, 1);
        send(5, 16'h0001, 1, 0);
    endtask

    task automatic t_range;
        send(32, 16'h0055, 1, 0);  // R1
        send(200, 16'h0007, 0, 0); // R1
        send(31, 16'h0003, 3, 0);
    endtask

    task automatic t_connect;
        send(8, 16'hFFF6, 3, 0);   // R8 channel 6
        send(8, 16'h0003, 0, 0);   // R8 channel 3
        send(9, 16'h0007, 3, 0);   // R8 zero for non-connect
    endtask

    task automatic t_trouble;
        send(4, 16'h0011, 2, 0);   // R5 R6 first: flag set
        send(10, 16'h0022, 2, 1);  // R6 irq pending: no cascade
        send(8, 16'h0005, 2, 0);   // R6 cascade
        send(3, 16'h0001, 1, 0);   // R7 clears trouble, cascade sticky
    endtask

    task automatic t_handshake;
        @(negedge clk);
        req_valid = 1'b1; req_num = 8'd12; req_sub = 16'h0; cycle_kind = 2'b11;
        e_fct = (e_fct + 1) % 8;
        e_trb = 0;
        @(negedge clk);
        chk("R10 first taken", fault_num, 12);
        chk("R10 busy low", req_ready, 0);
        req_num = 8'd14; cycle_kind = 2'b01;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 held request ignored num", fault_num, 12);
        chk("R10 held request ignored cyc", cyc_bits, 12'hA50 | e_fct);
        chk("R10 held request ignored icnt", instr_cnt, e_icnt);
        @(negedge clk);
    endtask

    task automatic t_wrap;
        for (int i = 0; i < 9; i++) send(i + 1, i, 3, 0); // R2 wraps past 7
    endtask

    initial begin
        e_fct = 5; e_icnt = 0; e_trb = 0; e_casc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_range();
        t_connect();
        t_trouble();
        t_handshake();
        t_wrap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule